// File: doc/BRIEF.md
# Condition Code Gate

This block decides, one instruction at a time, whether an instruction in the pipeline is allowed to take effect. Each instruction carries a 4-bit condition selector. The block tests that selector against the four arithmetic flags from the status word: negative, zero, carry and overflow. It then produces a registered execute strobe one cycle later. An instruction that fails its test is suppressed: it still passes through the stage, but it is marked so that it has no effect.

The block also gives a registered reserved-selector indication, and it keeps two saturating tallies, one of instructions that executed and one of instructions that were suppressed, so that whole runs can be checked at a glance. The flags come in as a 32-bit status word, with negative at bit 31, zero at bit 30, carry at bit 29 and overflow at bit 28. The carry flag also serves as the not-borrow result of subtract-based compares.

Top module: `cc_gate`

## Requirements
- R1: After reset (rst_n low), exec_q, rsvd_q, exec_cnt and supp_cnt are all 0.
- R2: exec_q is high in the cycle after a rising clock edge at which inst_vld was high and the selector passed. Otherwise it is low: one cycle of latency.
- R3: Simple flag selectors are tested as follows: 0000 passes when Z=1, 0001 when Z=0, 0010 when C=1, 0011 when C=0, 0100 when N=1, 0101 when N=0, 0110 when V=1 and 0111 when V=0. The flags are N at bit 31, Z at bit 30, C at bit 29 and V at bit 28 of status.
- R4: Unsigned compare selectors are tested as follows: 1000 passes when C=1 and Z=0, and 1001 passes when C=0 or Z=1.
- R5: Signed compare selectors are tested as follows: 1010 passes when N==V, 1011 when N!=V, 1100 when Z=0 and N==V, and 1101 when Z=1 or N!=V.
- R6: Selector 1110 always passes.
- R7: Selector 1111 never passes. rsvd_q is high in the cycle after a valid instruction that carries selector 1111, and low in every other cycle.
- R8: When inst_vld is low, exec_q stays low and neither tally changes, whatever the selector and flags are.
- R9: Each valid instruction adds 1 to exec_cnt if it passed, and 1 to supp_cnt if it did not. The two tallies update in the same cycle as exec_q.
- R10: Each tally saturates at its largest value, 65535 by default, and does not wrap.
- R11: cnt_clr high at a clock edge sets both tallies to 0 at that edge, and any count from the same edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inst_vld | input | 1 | Instruction present this cycle |
| cond_sel | input | 4 | Condition selector of the instruction |
| status | input | 32 | Status word; flags at bits 31..28 |
| cnt_clr | input | 1 | Synchronous clear of both tallies |
| exec_q | output | 1 | Registered execute strobe |
| rsvd_q | output | 1 | Registered reserved-selector flag |
| exec_cnt | output | 16 | Executed-instruction tally |
| supp_cnt | output | 16 | Suppressed-instruction tally |

## Verification
The bench drives all sixteen selectors against all sixteen flag combinations, and then randomized traffic, so that a swapped pair of encodings or an inverted signed compare shows up as a wrong exec_q. A design that tested N==V as N!=V would break GE, LT, GT and LE everywhere that N and V differ. A design that treated 1111 as always-pass would bump the executed tally instead of the suppressed tally and would miss rsvd_q. The bench also pushes a tally to its ceiling, where a wrapping counter would read 0. It checks that a clear arriving in the same cycle as a valid instruction leaves 0, not 1, and that invalid cycles with passing selectors leave everything unchanged.

// File: rtl/cc_gate_pkg.sv
// Package: shared selector encodings and the flag positions in the status word.
// Assumes a 32-bit status word with the flags in its top nibble.
package cc_gate_pkg;
    typedef enum logic [3:0] {
        SEL_EQ = 4'b0000, SEL_NE = 4'b0001, SEL_CS = 4'b0010, SEL_CC = 4'b0011,
        SEL_MI = 4'b0100, SEL_PL = 4'b0101, SEL_VS = 4'b0110, SEL_VC = 4'b0111,
        SEL_HI = 4'b1000, SEL_LS = 4'b1001, SEL_GE = 4'b1010, SEL_LT = 4'b1011,
        SEL_GT = 4'b1100, SEL_LE = 4'b1101, SEL_AL = 4'b1110, SEL_RS = 4'b1111
    } cond_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam int FLAG_N_POS = 31;
    localparam int FLAG_Z_POS = 30;
    localparam int FLAG_C_POS = 29;
    localparam int FLAG_V_POS = 28;
endpackage

// File: rtl/cc_flag_extract.sv
// Module: pulls the four condition flags out of the status word.
// Assumes the flag positions given in cc_gate_pkg.
module cc_flag_extract
    import cc_gate_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0] status,
    output flags_t            flags
);
    // Purpose: route the flag bits into a named struct.
    always_comb begin
        flags.n = status[FLAG_N_POS];
        flags.z = status[FLAG_Z_POS];
        flags.c = status[FLAG_C_POS];
        flags.v = status[FLAG_V_POS];
    end
endmodule

// File: rtl/cc_cond_eval.sv
// Module: combinational evaluation of a 4-bit selector against the flags.
// The upper three bits of the selector choose a base test and bit 0 inverts it.
// Selector 1110 always passes; selector 1111 never passes and is flagged as reserved.
module cc_cond_eval
    import cc_gate_pkg::*;
(
    input  logic [3:0] sel,
    input  flags_t     flags,
    output logic       pass,
    output logic       rsvd
);
    logic base;

    // Purpose: compute the base test chosen by sel[3:1].
    always_comb begin
        case (sel[3:1])
            3'd0:    base = flags.z;
            3'd1:    base = flags.c;
            3'd2:    base = flags.n;
            3'd3:    base = flags.v;
            3'd4:    base = flags.c & ~flags.z;
            3'd5:    base = (flags.n == flags.v);
            3'd6:    base = ~flags.z & (flags.n == flags.v);
            default: base = 1'b1;
        endcase
    end

    // Purpose: apply the inversion bit and handle the always and reserved selectors.
    always_comb begin
        rsvd = (sel == SEL_RS);
        if (sel[3:1] == 3'd7) pass = ~sel[0];
        else                  pass = base ^ sel[0];
    end
endmodule

// File: rtl/cc_sat_counter.sv
// Module: saturating up-counter with synchronous clear (clear wins over increment).
// Assumes a synchronous active-low reset.
module cc_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Purpose: reset, clear, or increment the count while it is below the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr)                    cnt <= '0;
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cc_gate.sv
// Top: condition code gate. Registers the execute and reserved indications for one
// stage, and keeps saturating tallies of executed and suppressed instructions.
// Assumes the selector and status are valid whenever inst_vld is high.
module cc_gate
    import cc_gate_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_vld,
    input  logic [3:0]       cond_sel,
    input  logic [STAT_W-1:0] status,
    input  logic             cnt_clr,
    output logic             exec_q,
    output logic             rsvd_q,
    output logic [CNT_W-1:0] exec_cnt,
    output logic [CNT_W-1:0] supp_cnt
);
    flags_t flags;
    logic   pass, rsvd;
    logic   do_exec, do_supp;

    cc_flag_extract #(.STAT_W(STAT_W)) u_flags (.status(status), .flags(flags));
    cc_cond_eval u_eval (.sel(cond_sel), .flags(flags), .pass(pass), .rsvd(rsvd));

    // Purpose: qualify the test result with the valid strobe.
    always_comb begin
        do_exec = inst_vld & pass;
        do_supp = inst_vld & ~pass;
    end

    // Purpose: pipeline register for the execute and reserved indications.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= 1'b0;
            rsvd_q <= 1'b0;
        end else begin
            exec_q <= do_exec;
            rsvd_q <= inst_vld & rsvd;
        end
    end

    cc_sat_counter #(.CNT_W(CNT_W)) u_exec_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(do_exec), .cnt(exec_cnt));
    cc_sat_counter #(.CNT_W(CNT_W)) u_supp_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(do_supp), .cnt(supp_cnt));
endmodule

// File: rtl/cc_gate_chk.sv
// Checker: temporal properties of the condition code gate, bound to the top.
module cc_gate_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inst_vld,
    input logic [3:0]       cond_sel,
    input logic             cnt_clr,
    input logic             exec_q,
    input logic             rsvd_q,
    input logic [CNT_W-1:0] exec_cnt,
    input logic [CNT_W-1:0] supp_cnt
);
    // R8
    idle_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_vld |=> !exec_q);
    // R8
    idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inst_vld && !cnt_clr) |=> ($stable(exec_cnt) && $stable(supp_cnt)));
    // R7
    rsvd_never_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_vld && cond_sel == 4'hF) |=> (rsvd_q && !exec_q));
    // R6
    always_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_vld && cond_sel == 4'hE) |=> exec_q);
    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (exec_cnt == '0 && supp_cnt == '0));
    // R10
    exec_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cnt == {CNT_W{1'b1}} && !cnt_clr) |=> exec_cnt == {CNT_W{1'b1}});
    // R10
    supp_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supp_cnt == {CNT_W{1'b1}} && !cnt_clr) |=> supp_cnt == {CNT_W{1'b1}});
endmodule

bind cc_gate cc_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inst_vld(inst_vld), .cond_sel(cond_sel),
    .cnt_clr(cnt_clr), .exec_q(exec_q), .rsvd_q(rsvd_q),
    .exec_cnt(exec_cnt), .supp_cnt(supp_cnt));

// File: tb/cc_gate_tb_top.sv
// Bench: behavioural reference model compared against the design on every clock.
module cc_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        inst_vld;
    logic [3:0]  cond_sel;
    logic [31:0] status;
    logic        cnt_clr;
    logic        exec_q, rsvd_q;
    logic [15:0] exec_cnt, supp_cnt;

    int checks = 0;
    int fails  = 0;
    int m_exec, m_supp;
    bit m_eq, m_rq;
    bit done = 0;

    always #5 clk = ~clk;

    cc_gate dut_i (
        .clk(clk), .rst_n(rst_n), .inst_vld(inst_vld), .cond_sel(cond_sel),
        .status(status), .cnt_clr(cnt_clr), .exec_q(exec_q), .rsvd_q(rsvd_q),
        .exec_cnt(exec_cnt), .supp_cnt(supp_cnt));

    // Reference truth for one selector: built from the written requirements.
    function automatic bit ref_pass(input logic [3:0] s, input logic [31:0] st);
        bit n, z, c, v;
        n = st[31]; z = st[30]; c = st[29]; v = st[28];
        case (s)
            4'd0:  return z;            // R3
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;      // R4
            4'd9:  return !c || z;
            4'd10: return n == v;       // R5
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1;            // R6
            default: return 0;          // R7
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] s);
        if (s <= 4'd7) return "R3";
        if (s <= 4'd9) return "R4";
        if (s <= 4'd13) return "R5";
        if (s == 4'd14) return "R6";
        return "R7";
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle, update the model at the edge and compare after it.
    task automatic step(input bit vld, input logic [3:0] s, input logic [31:0] st,
                        input bit clr, input string req);
        bit p;
        inst_vld = vld; cond_sel = s; status = st; cnt_clr = clr;
        p = ref_pass(s, st);
        @(posedge clk);
        m_eq = vld && p;
        m_rq = vld && (s == 4'hF);
        if (clr) begin
            m_exec = 0; m_supp = 0;
        end else if (vld) begin
            if (p && m_exec < 65535) m_exec++;
            if (!p && m_supp < 65535) m_supp++;
        end
        #2;
        chk({req, "/R2 exec_q"}, exec_q, m_eq);
        chk("R7 rsvd_q", rsvd_q, m_rq);
        chk("R9 exec_cnt", exec_cnt, m_exec);
        chk("R9 supp_cnt", supp_cnt, m_supp);
    endtask

    initial begin
        rst_n = 0; inst_vld = 0; cond_sel = 0; status = 0; cnt_clr = 0;
        m_exec = 0; m_supp = 0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 exec_q", exec_q, 0);
        chk("R1 rsvd_q", rsvd_q, 0);
        chk("R1 exec_cnt", exec_cnt, 0);
        chk("R1 supp_cnt", supp_cnt, 0);
        @(negedge clk); rst_n = 1;
        // Exhaustive selector x flag sweep (R3, R4, R5, R6, R7).
        for (int s = 0; s < 16; s++)
            for (int f = 0; f < 16; f++)
                step(1, s[3:0], {f[3:0], 28'h0ABCDEF}, 0, req_of(s[3:0]));
        // R8: invalid cycles with always-pass and reserved selectors change nothing.
        for (int i = 0; i < 8; i++)
            step(0, (i % 2) ? 4'hE : 4'hF, 32'hF000_0000, 0, "R8");
        // R11: clear in the same cycle as a valid instruction.
        step(1, 4'hE, 0, 1, "R11");
        chk("R11 exec_cnt after clear", exec_cnt, 0);
        // Randomized traffic.
        for (int i = 0; i < 2000; i++)
            step(($urandom % 4) != 0, 4'($urandom), $urandom, ($urandom % 300) == 0,
                 "R2");
        // R10: drive executed tally to saturation and beyond.
        step(1, 4'hE, 0, 1, "R11");
        for (int i = 0; i < 65540; i++) step(1, 4'hE, 0, 0, "R10");
        chk("R10 exec_cnt saturated", exec_cnt, 65535);
        step(1, 4'hF, 0, 0, "R10");
        chk("R10 supp_cnt", supp_cnt, 1);
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule